// File: doc/BRIEF.md
# SDRAM Command Sequencer with Refresh

This block sits between a simple host request port and a four-bank synchronous DRAM. It turns single read and write requests into the DRAM command stream: chip select, row strobe, column strobe, write enable, bank select and multiplexed address. After reset it waits a programmable power-up time. It then closes all banks, issues a set of auto-refresh commands and loads the mode register. Only after that does it accept host traffic.

In normal operation each bank keeps its own row open until a request for another row in that bank arrives, or until a refresh is due. Requests carry a packed `{bank, row, column}` address. The host holds the request until it sees a one-cycle acknowledge, and that acknowledge appears in the same cycle as the matching read or write command. Every minimum command spacing is a parameter, counted in clocks. The defaults suit a 133 MHz clock with CAS latency 3.

A free-running interval counter raises a refresh request. Refresh has priority over new row openings and column accesses. The block closes every open row, issues one auto refresh, and then keeps all banks blocked for a full row cycle. The data path and the pin drivers are not part of this block.

Top module: `sdram_seq`

## Requirements
- R1: Commands are driven as {cs_n, ras_n, cas_n, we_n}. The codes are: 0000 mode load, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 auto refresh and 0111 no-op. During reset the pins carry no-op, and acknowledge and refresh-busy are low.
- R2: After reset the pins carry no-op for at least T_INIT clocks. The first commands are then, in this order: one precharge with address bit 10 high, INIT_REFS auto refreshes, and a mode load whose address equals MODE_WORD. No request is acknowledged before the mode load.
- R3: No command follows a mode load within T_MRD clocks. No activate, refresh or mode load follows an auto refresh within T_RC clocks.
- R4: A read or write to a bank comes at least T_RCD clocks after that bank's activate.
- R5: A precharge of an open bank comes at least T_RAS clocks after its activate and at least T_WR clocks after its last write.
- R6: An activate targets a closed bank. It comes at least T_RC clocks after the previous activate of the same bank and at least T_RP clocks after that bank's precharge. It comes at least T_RRD clocks after an activate of any bank.
- R7: A request whose bank has the same row open is served by a single read (request write flag 0) or write (flag 1), with no new activate. The command carries the request's bank on BA and its column on address bits COL_W-1:0, with address bit 10 low.
- R8: A request to a bank holding a different row first closes only that bank, using a precharge with bit 10 low and BA set to the bank. It then activates the new row, sent on the address pins, before the access.
- R9: Opening or closing a row in one bank leaves the rows open in the other banks untouched, so later hits on them need no activate.
- R10: Once every REF_INTERVAL clocks a refresh becomes due. All open rows are closed by a precharge with bit 10 high, and then an auto refresh is issued while all banks are closed. Refresh-busy is high from the moment the refresh is due until T_RC clocks after the refresh.
- R11: While refresh-busy is high, no activate, read or write is issued and pending host requests are not acknowledged.
- R12: The acknowledge is high for exactly one cycle per request, in the cycle its read or write command is on the pins, and never with any other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request valid, held until acknowledged |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | BANK_W+ROW_W+COL_W | Packed {bank, row, column} |
| ack_o | output | 1 | Request accepted; its column command is on the pins |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | BANK_W | Bank select |
| sd_addr_o | output | ROW_W | Row, column or mode word; bit 10 selects all banks / auto-precharge |
| ref_busy_o | output | 1 | Refresh due or its row-cycle window still running |

## Verification
The hardest case to reach from the ports is a refresh that becomes due while several banks hold open rows. In that case some rows have not yet met their active time or write recovery, and a host request is waiting. The bench shortens the refresh interval and waits for refresh-busy to rise. It then presents a request to a bank it has just opened, so that the close-all, refresh and blocked row-cycle window all fall between the request and its acknowledge. A pin monitor rebuilds the bank state from the command stream alone, checks every spacing rule on each command, and matches each column command against a queue of expected requests.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT, ST_PREA, ST_IREF, ST_MRS, ST_RUN
  } st_e;
endpackage

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int ROW_W = 13,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 9,
  parameter int T_RP  = 3,
  parameter int T_WR  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             wr_i,
  input  logic             pre_i,
  input  logic             ref_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rw_ok_o,
  output logic             pre_ok_o,
  output logic             act_ok_o
);
  localparam int M1 = (T_RC > T_RAS) ? T_RC : T_RAS;
  localparam int M2 = (M1 > T_RCD) ? M1 : T_RCD;
  localparam int M3 = (M2 > T_RP) ? M2 : T_RP;
  localparam int M4 = (M3 > T_WR) ? M3 : T_WR;
  localparam int CW = $clog2(M4 + 1);
  localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_WR  = CW'(T_WR - 1);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    rcd_q, hold_pre_q, hold_act_q;
  logic [CW-1:0]    rcd_dec, pre_dec, act_dec;

  assign rcd_dec = (rcd_q == '0) ? '0 : rcd_q - CW'(1);
  assign pre_dec = (hold_pre_q == '0) ? '0 : hold_pre_q - CW'(1);
  assign act_dec = (hold_act_q == '0) ? '0 : hold_act_q - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q     <= 1'b0;
      row_q      <= '0;
      rcd_q      <= '0;
      hold_pre_q <= '0;
      hold_act_q <= '0;
    end else begin
      rcd_q <= act_i ? L_RCD : rcd_dec;
      if (act_i)                        hold_pre_q <= L_RAS;
      else if (wr_i && pre_dec < L_WR)  hold_pre_q <= L_WR;
      else                              hold_pre_q <= pre_dec;
      if (act_i || ref_i)               hold_act_q <= L_RC;
      else if (pre_i && act_dec < L_RP) hold_act_q <= L_RP;
      else                              hold_act_q <= act_dec;
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (pre_i) begin
        open_q <= 1'b0;
      end
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign rw_ok_o  = open_q && (rcd_q == '0);
  assign pre_ok_o = (hold_pre_q == '0);
  assign act_ok_o = !open_q && (hold_act_q == '0);

  p_act_closed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_q && hold_act_q == '0);
  p_pre_ras_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && open_q) |-> hold_pre_q == '0);
  p_wr_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> open_q && rcd_q == '0);
  p_open_after_act_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i) |=> open_o && row_o == $past(row_i));
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int INTERVAL = 1040,
  parameter int T_RC     = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic pend_o,
  output logic busy_o
);
  localparam int IW = $clog2(INTERVAL + 1);
  localparam int RW = $clog2(T_RC + 1);
  localparam logic [IW-1:0] L_IV = IW'(INTERVAL - 1);
  localparam logic [RW-1:0] L_RC = RW'(T_RC - 1);

  logic [IW-1:0] iv_q;
  logic [RW-1:0] rfc_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iv_q   <= L_IV;
      rfc_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      iv_q <= (iv_q == '0) ? L_IV : iv_q - IW'(1);
      if (iv_q == '0) pend_q <= 1'b1;
      else if (ref_i) pend_q <= 1'b0;
      if (ref_i)              rfc_q <= L_RC;
      else if (rfc_q != '0)   rfc_q <= rfc_q - RW'(1);
    end
  end

  assign pend_o = pend_q;
  assign busy_o = pend_q || (rfc_q != '0);

  p_pend_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ref_i) |=> pend_q);
  p_busy_after_ref_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_i |=> busy_o);
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int BANK_W       = 2,
  parameter int T_INIT       = 26667,
  parameter int INIT_REFS    = 2,
  parameter logic [ROW_W-1:0] MODE_WORD = 'h030,
  parameter int T_MRD        = 2,
  parameter int T_RCD        = 3,
  parameter int T_RAS        = 6,
  parameter int T_RC         = 9,
  parameter int T_RP         = 3,
  parameter int T_RRD        = 2,
  parameter int T_WR         = 2,
  parameter int REF_INTERVAL = 1040
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          req_we_i,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr_i,
  output logic                          ack_o,
  output logic                          sd_cs_no,
  output logic                          sd_ras_no,
  output logic                          sd_cas_no,
  output logic                          sd_we_no,
  output logic [BANK_W-1:0]             sd_ba_o,
  output logic [ROW_W-1:0]              sd_addr_o,
  output logic                          ref_busy_o
);
  localparam int NB  = 1 << BANK_W;
  localparam int AW  = BANK_W + ROW_W + COL_W;
  localparam int AP  = 10;  // all-banks / auto-precharge bit
  localparam int WW  = $clog2(T_INIT + 1);
  localparam int IRW = $clog2(INIT_REFS + 1);
  localparam int SW  = $clog2(((T_MRD > T_RRD) ? T_MRD : T_RRD) + 1);
  localparam logic [WW-1:0]  L_INIT = WW'(T_INIT - 1);
  localparam logic [IRW-1:0] L_IREF = IRW'(INIT_REFS - 1);
  localparam logic [SW-1:0]  L_MRD  = SW'(T_MRD - 1);
  localparam logic [SW-1:0]  L_RRD  = SW'(T_RRD - 1);

  st_e              state_q, state_d;
  cmd_e             cmd_q, nxt_cmd;
  logic [BANK_W-1:0] ba_q, nxt_ba;
  logic [ROW_W-1:0] addr_q, nxt_addr;
  logic             ack_q, nxt_ack;
  logic [WW-1:0]    wait_q;
  logic [IRW-1:0]   iref_q;
  logic [SW-1:0]    mrd_q, rrd_q;
  logic             ref_pend, ref_s;

  logic [NB-1:0]    open_v, rw_ok_v, pre_ok_v, act_ok_v;
  logic [NB-1:0]    act_s, wr_s, pre_s;
  logic [ROW_W-1:0] row_v [NB];

  logic [BANK_W-1:0] rq_bank;
  logic [ROW_W-1:0]  rq_row;
  logic [COL_W-1:0]  rq_col;
  logic              all_act_ok, pre_all_ok;

  assign rq_bank    = req_addr_i[AW-1 -: BANK_W];
  assign rq_row     = req_addr_i[COL_W +: ROW_W];
  assign rq_col     = req_addr_i[COL_W-1:0];
  assign all_act_ok = &act_ok_v;
  assign pre_all_ok = &(pre_ok_v | ~open_v);

  always_comb begin
    state_d  = state_q;
    nxt_cmd  = CMD_NOP;
    nxt_ba   = '0;
    nxt_addr = '0;
    nxt_ack  = 1'b0;
    unique case (state_q)
      ST_WAIT: if (wait_q == '0) state_d = ST_PREA;
      ST_PREA: begin
        nxt_cmd      = CMD_PRE;
        nxt_addr[AP] = 1'b1;
        state_d      = ST_IREF;
      end
      ST_IREF: if (all_act_ok) begin
        nxt_cmd = CMD_REF;
        if (iref_q == L_IREF) state_d = ST_MRS;
      end
      ST_MRS: if (all_act_ok) begin
        nxt_cmd  = CMD_MRS;
        nxt_addr = MODE_WORD;
        state_d  = ST_RUN;
      end
      ST_RUN: if (mrd_q == '0) begin
        if (ref_pend) begin
          // close everything, then refresh
          if (|open_v) begin
            if (pre_all_ok) begin
              nxt_cmd      = CMD_PRE;
              nxt_addr[AP] = 1'b1;
            end
          end else if (all_act_ok) begin
            nxt_cmd = CMD_REF;
          end
        end else if (req_i && !ack_q) begin
          nxt_ba = rq_bank;
          if (open_v[rq_bank] && row_v[rq_bank] == rq_row) begin
            if (rw_ok_v[rq_bank]) begin
              nxt_cmd  = req_we_i ? CMD_WR : CMD_RD;
              nxt_addr = ROW_W'(rq_col);
              nxt_ack  = 1'b1;
            end
          end else if (open_v[rq_bank]) begin
            if (pre_ok_v[rq_bank]) nxt_cmd = CMD_PRE;
          end else if (act_ok_v[rq_bank] && rrd_q == '0) begin
            nxt_cmd  = CMD_ACT;
            nxt_addr = rq_row;
          end
        end
      end
      default: state_d = ST_WAIT;
    endcase
  end

  assign ref_s = (nxt_cmd == CMD_REF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      ack_q   <= 1'b0;
      wait_q  <= L_INIT;
      iref_q  <= '0;
      mrd_q   <= '0;
      rrd_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= nxt_cmd;
      ba_q    <= nxt_ba;
      addr_q  <= nxt_addr;
      ack_q   <= nxt_ack;
      if (wait_q != '0) wait_q <= wait_q - WW'(1);
      if (state_q == ST_IREF && ref_s) iref_q <= iref_q + IRW'(1);
      if (nxt_cmd == CMD_MRS)  mrd_q <= L_MRD;
      else if (mrd_q != '0)    mrd_q <= mrd_q - SW'(1);
      if (nxt_cmd == CMD_ACT)  rrd_q <= L_RRD;
      else if (rrd_q != '0)    rrd_q <= rrd_q - SW'(1);
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign act_s[g] = (nxt_cmd == CMD_ACT) && (nxt_ba == BANK_W'(g));
    assign wr_s[g]  = (nxt_cmd == CMD_WR) && (nxt_ba == BANK_W'(g));
    assign pre_s[g] = (nxt_cmd == CMD_PRE) && (nxt_addr[AP] || nxt_ba == BANK_W'(g));
    sdram_bank_timer #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
      .T_RC(T_RC), .T_RP(T_RP), .T_WR(T_WR)
    ) bank_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (act_s[g]),
      .row_i   (nxt_addr),
      .wr_i    (wr_s[g]),
      .pre_i   (pre_s[g]),
      .ref_i   (ref_s),
      .open_o  (open_v[g]),
      .row_o   (row_v[g]),
      .rw_ok_o (rw_ok_v[g]),
      .pre_ok_o(pre_ok_v[g]),
      .act_ok_o(act_ok_v[g])
    );
  end

  sdram_ref_timer #(.INTERVAL(REF_INTERVAL), .T_RC(T_RC)) ref_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_i (ref_s),
    .pend_o(ref_pend),
    .busy_o(ref_busy_o)
  );

  assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd_q;
  assign sd_ba_o   = ba_q;
  assign sd_addr_o = addr_q;
  assign ack_o     = ack_q;

  p_ack_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> open_v[ba_q]);
  p_ack_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  p_ref_closed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_REF) |-> open_v == '0);
  p_pend_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && ref_pend) |=> cmd_q != CMD_ACT && !ack_q);
  p_mrd_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_MRS) |=> cmd_q == CMD_NOP);
  p_init_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |-> !ack_q);
endmodule

// File: tb/sdram_seq_tb.sv
`timescale 1ns/1ps
module sdram_seq_tb_top;
  localparam int ROW_W = 13, COL_W = 10, BANK_W = 2, NB = 4;
  localparam int AW = BANK_W + ROW_W + COL_W;
  localparam int T_INIT = 20, INIT_REFS = 2, T_MRD = 2, T_RCD = 3, T_RAS = 6;
  localparam int T_RC = 9, T_RP = 3, T_RRD = 2, T_WR = 2, REF_IV = 150;
  localparam logic [ROW_W-1:0] MODE = 13'h030;
  localparam int WD = 100000, SLACK = 20;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
    C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic ack_o, sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no, ref_busy_o;
  logic [BANK_W-1:0] sd_ba_o;
  logic [ROW_W-1:0] sd_addr_o;

  always #2.5 clk_i = ~clk_i;

  sdram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .T_INIT(T_INIT),
    .INIT_REFS(INIT_REFS), .MODE_WORD(MODE), .T_MRD(T_MRD), .T_RCD(T_RCD),
    .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP), .T_RRD(T_RRD), .T_WR(T_WR),
    .REF_INTERVAL(REF_IV)
  ) dut_i (
    .clk_i, .rst_ni, .req_i, .req_we_i, .req_addr_i, .ack_o,
    .sd_cs_no, .sd_ras_no, .sd_cas_no, .sd_we_no, .sd_ba_o, .sd_addr_o,
    .ref_busy_o
  );

  typedef struct { bit we; int bank; int row; int col; } item_t;
  item_t exp_q[$];
  int errors = 0, checks = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // pin monitor state
  int cyc = 0, t_act_any = -1000, t_ref = -1000, t_mrs = -1000, last_run_ref = -1;
  int t_act[NB], t_pre[NB], t_wr[NB], row_m[NB];
  bit open_m[NB];
  bit run_m = 0, seen_cmd = 0, prev_busy = 0;
  int init_idx = 0, n_ref = 0, n_act = 0, n_pre1 = 0;

  initial for (int k = 0; k < NB; k++) begin
    t_act[k] = -1000; t_pre[k] = -1000; t_wr[k] = -1000; open_m[k] = 0; row_m[k] = 0;
  end

  task automatic monitor();
    logic [3:0] c;
    int b;
    bit ap;
    item_t it;
    c  = {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no};
    b  = int'(sd_ba_o);
    ap = sd_addr_o[10];
    cyc++;
    if (cyc > WD) begin
      chk(0, "R12", "watchdog expired", cyc, WD);
      finish_run();
    end
    if (c != C_NOP) begin
      if (!seen_cmd) chk(cyc >= T_INIT, "R2", "first command cycle", cyc, T_INIT);
      seen_cmd = 1;
      if (run_m) chk(cyc - t_mrs >= T_MRD, "R3", "mode load spacing", cyc - t_mrs, T_MRD);
      if (!run_m) begin
        if (init_idx == 0)
          chk(c == C_PRE && ap, "R2", "init precharge-all", int'(c), int'(C_PRE));
        else if (init_idx <= INIT_REFS)
          chk(c == C_REF, "R2", "init refresh", int'(c), int'(C_REF));
        else begin
          chk(c == C_MRS, "R2", "init mode load", int'(c), int'(C_MRS));
          chk(sd_addr_o == MODE, "R2", "mode word", int'(sd_addr_o), int'(MODE));
        end
        init_idx++;
      end
    end
    if (ack_o && c != C_RD && c != C_WR) chk(0, "R12", "ack without column cmd", int'(c), int'(C_RD));
    case (c)
      C_NOP: ;
      C_RD, C_WR: begin
        chk(run_m, "R2", "access before mode load", 0, 1);
        chk(open_m[b], "R7", "access to closed bank", 0, 1);
        chk(cyc - t_act[b] >= T_RCD, "R4", "act to access", cyc - t_act[b], T_RCD);
        chk(ack_o, "R12", "ack with column cmd", int'(ack_o), 1);
        chk(!ap, "R7", "bit10 on access", int'(ap), 0);
        chk(!prev_busy, "R11", "access while refresh busy", 1, 0);
        if (exp_q.size() == 0) chk(0, "R12", "unexpected access", 1, 0);
        else begin
          it = exp_q.pop_front();
          chk(it.we == (c == C_WR), "R7", "direction", int'(c == C_WR), int'(it.we));
          chk(it.bank == b, "R7", "bank", b, it.bank);
          chk(it.col == int'(sd_addr_o[COL_W-1:0]), "R7", "column", int'(sd_addr_o[COL_W-1:0]), it.col);
          chk(it.row == row_m[b], "R8", "open row", row_m[b], it.row);
        end
        if (c == C_WR) t_wr[b] = cyc;
      end
      C_ACT: begin
        chk(!open_m[b], "R6", "activate of open bank", 1, 0);
        chk(cyc - t_act[b] >= T_RC, "R6", "act to act same bank", cyc - t_act[b], T_RC);
        chk(cyc - t_pre[b] >= T_RP, "R6", "pre to act", cyc - t_pre[b], T_RP);
        chk(cyc - t_act_any >= T_RRD, "R6", "act to act any bank", cyc - t_act_any, T_RRD);
        chk(cyc - t_ref >= T_RC, "R3", "refresh to act", cyc - t_ref, T_RC);
        chk(!prev_busy, "R11", "activate while refresh busy", 1, 0);
        open_m[b] = 1; row_m[b] = int'(sd_addr_o);
        t_act[b] = cyc; t_act_any = cyc; n_act++;
      end
      C_PRE: begin
        if (!ap) begin
          n_pre1++;
          chk(open_m[b], "R8", "single precharge of open bank", 0, 1);
        end
        for (int k = 0; k < NB; k++) if (ap || k == b) begin
          if (open_m[k]) begin
            chk(cyc - t_act[k] >= T_RAS, "R5", "act to pre", cyc - t_act[k], T_RAS);
            chk(cyc - t_wr[k] >= T_WR, "R5", "write to pre", cyc - t_wr[k], T_WR);
          end
          open_m[k] = 0; t_pre[k] = cyc;
        end
      end
      C_REF: begin
        for (int k = 0; k < NB; k++) begin
          chk(!open_m[k], "R10", "refresh with open row", 1, 0);
          chk(cyc - t_pre[k] >= T_RP, "R6", "pre to refresh", cyc - t_pre[k], T_RP);
        end
        chk(cyc - t_ref >= T_RC, "R3", "refresh to refresh", cyc - t_ref, T_RC);
        if (run_m) begin
          chk(ref_busy_o, "R10", "busy at refresh", int'(ref_busy_o), 1);
          if (last_run_ref >= 0)
            chk(cyc - last_run_ref <= REF_IV + SLACK, "R10", "refresh gap", cyc - last_run_ref, REF_IV);
          last_run_ref = cyc; n_ref++;
        end
        t_ref = cyc;
      end
      C_MRS: begin
        for (int k = 0; k < NB; k++) chk(!open_m[k], "R2", "mode load with open row", 1, 0);
        chk(cyc - t_ref >= T_RC, "R3", "refresh to mode load", cyc - t_ref, T_RC);
        t_mrs = cyc; run_m = 1;
      end
      default: chk(0, "R1", "illegal command code", int'(c), int'(C_NOP));
    endcase
    prev_busy = ref_busy_o;
  endtask

  always @(negedge clk_i) if (rst_ni) monitor();

  // driver: queue the expectation, hold the request until ack
  task automatic do_req(bit we, int bank, int row, int col);
    item_t it;
    it.we = we; it.bank = bank; it.row = row; it.col = col;
    exp_q.push_back(it);
    req_we_i   = we;
    req_addr_i = {BANK_W'(bank), ROW_W'(row), COL_W'(col)};
    req_i      = 1'b1;
    do @(negedge clk_i); while (!ack_o);
    req_i = 1'b0;
  endtask

  task automatic wait_busy(bit level);
    do @(negedge clk_i); while (ref_busy_o != level);
  endtask

  int a0, r0, seed;

  initial begin
    repeat (2) @(negedge clk_i);
    chk({sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} == C_NOP, "R1", "reset pins",
        int'({sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no}), int'(C_NOP));
    chk(!ack_o && !ref_busy_o, "R1", "reset ack/busy", int'({ack_o, ref_busy_o}), 0);
    rst_ni = 1'b1;
    while (!run_m) @(negedge clk_i);

    // R7 hits, R8 miss with write recovery before precharge
    do_req(0, 0, 5, 1);
    do_req(1, 0, 5, 2);
    do_req(0, 0, 5, 3);
    do_req(1, 0, 9, 4);
    do_req(0, 0, 5, 6);

    // R9: all four banks, then hits without activates, inside a refresh-free window
    wait_busy(1); wait_busy(0);
    r0 = n_ref;
    for (int k = 0; k < NB; k++) do_req(0, k, 10 + k, k);
    a0 = n_act;
    do_req(0, 0, 10, 7);
    do_req(1, 2, 12, 8);
    do_req(0, 3, 13, 9);
    chk(n_ref != r0 || n_act == a0, "R9", "activates on hits", n_act - a0, 0);

    // R10/R11: request lands while refresh is due and rows are open
    do_req(1, 1, 20, 3);
    wait_busy(0); wait_busy(1);
    r0 = n_ref;
    do_req(0, 1, 20, 4);
    chk(n_ref == r0 + 1, "R11", "request served after refresh", n_ref - r0, 1);

    // mixed traffic
    seed = 7;
    for (int i = 0; i < 60; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      do_req(bit'(seed[3]), (seed >> 4) & 3, (seed >> 6) & 3, (seed >> 8) & 1023);
    end

    repeat (400) @(negedge clk_i);
    chk(exp_q.size() == 0, "R12", "requests left unacked", exp_q.size(), 0);
    chk(n_ref >= cyc / REF_IV - 2, "R10", "refresh count", n_ref, cyc / REF_IV - 2);
    chk(n_pre1 > 0, "R8", "single-bank precharges", n_pre1, 1);
    finish_run();
  end
endmodule